// File: doc/BRIEF.md
# EDH Error-Flag Port Transfer Controller

This block carries EDH error flags between two video error-detection devices over a small parallel port. The port has a 5-bit flag bus and a 2-bit group select. The block keeps a bank of outgoing flags with three groups:

| Select code | Group |
|-------------|-------|
| 01 | ancillary |
| 00 | full-field |
| 10 | active-picture |

In transmit mode the block plays the three groups onto the port after every decoded EDH packet. In write mode it takes groups that a peer drives onto the port and stores them in the bank. A host write path can also update the bank.

Transmit mode needs both the map pin and the read/write pin high. Write mode needs both pins low. The port is enabled only after a settling delay. An EDH bypass control freezes the bank and forces every flag the block presents to zero.

Top module: `edh_flag_port`

## Requirements
- R1: After reset, `port_sel_out` is 01, `port_oe` is 0, and every group reads zero on `rd_flags`.
- R2: Once `map_en` and `rw_sel` are both high, `port_oe` goes high after `EN_DLY` rising edges (default 2). It falls in the same cycle that either pin drops.
- R3: A `pkt_valid` strobe loads all three groups into the bank. From the cycle after the strobe edge, the port shows select 01 with the ancillary flags for two cycles, then 00 with the full-field flags for two cycles, then 10 with the active-picture flags for two cycles.
- R4: `port_sel_out` never takes the value 11.
- R5: When no sequence is running, `port_sel_out` rests at 01 and `port_fl_out` shows the ancillary group of the last loaded packet.
- R6: A strobe that arrives during a sequence restarts it at select 01, using the new flags.
- R7: In write mode (`map_en`=0 and `rw_sel`=0), `port_fl_in` is stored into the group named by `port_sel_in` (00, 01 or 10) on each edge. A select of 11 stores nothing, and port data is not stored outside write mode.
- R8: `host_we` stores `host_data` into the group named by `host_sel`. If a port write targets the same group in the same cycle, the port value wins.
- R9: While `bypass` is high, `port_fl_out` and `rd_flags` read zero, and packet, port and host writes leave the bank unchanged. Once `bypass` falls, the earlier contents show again.
- R10: `rd_flags` returns the bank group named by `rd_sel` (00, 01 or 10) combinationally. It returns zero for `rd_sel` = 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output pixel clock |
| rst_n | input | 1 | Active-low reset |
| map_en | input | 1 | Map (transmit) mode pin |
| rw_sel | input | 1 | Read/write pin |
| bypass | input | 1 | EDH bypass |
| pkt_valid | input | 1 | Strobe: an EDH packet has been decoded |
| pkt_anc | input | FW | Decoded ancillary flags |
| pkt_full | input | FW | Decoded full-field flags |
| pkt_actv | input | FW | Decoded active-picture flags |
| port_fl_in | input | FW | Flag bus driven by the peer |
| port_sel_in | input | 2 | Group select driven by the peer |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host target group |
| host_data | input | FW | Host write data |
| rd_sel | input | 2 | Group to read |
| rd_flags | output | FW | Outgoing flags of the selected group |
| port_sel_out | output | 2 | Transmitted group select |
| port_fl_out | output | FW | Transmitted flag bus |
| port_oe | output | 1 | Port output enable (low means high impedance) |

## Verification
The transmit pattern is registered. The first pair appears in the cycle after the edge that samples `pkt_valid`, and each later pair lasts two cycles. For every strobe, the scoreboard queues one expected select, flag and enable value per cycle. It compares them 1 ns after each rising edge, one entry per edge.

`port_oe` rises `EN_DLY` edges after both mode pins are high and falls combinationally, so its fall is checked 1 ns after the pin drops. Bank writes from the port or host take effect at the next edge. `rd_flags` is combinational, so each read is checked 1 ns after `rd_sel` is driven on a falling edge.

// File: rtl/edh_flag_port.sv
module edh_flag_port #(
  parameter int FW     = 5,
  parameter int EN_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          map_en,
  input  logic          rw_sel,
  input  logic          bypass,
  input  logic          pkt_valid,
  input  logic [FW-1:0] pkt_anc,
  input  logic [FW-1:0] pkt_full,
  input  logic [FW-1:0] pkt_actv,
  input  logic [FW-1:0] port_fl_in,
  input  logic [1:0]    port_sel_in,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [FW-1:0] host_data,
  input  logic [1:0]    rd_sel,
  output logic [FW-1:0] rd_flags,
  output logic [1:0]    port_sel_out,
  output logic [FW-1:0] port_fl_out,
  output logic          port_oe
);
  localparam int CW = $clog2(EN_DLY + 2);

  logic [FW-1:0] bank [4];
  logic [FW-1:0] pkt_grp [3];
  logic [CW-1:0] dly;
  logic          busy;
  logic [2:0]    ph;

  wire tx_req  = map_en & rw_sel;
  wire wr_mode = ~map_en & ~rw_sel;
  wire port_wr = wr_mode & (port_sel_in != 2'b11);

  assign pkt_grp[0] = pkt_full;
  assign pkt_grp[1] = pkt_anc;
  assign pkt_grp[2] = pkt_actv;

  assign port_oe = tx_req && (dly == CW'(EN_DLY));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   dly <= '0;
    else if (!tx_req)             dly <= '0;
    else if (dly != CW'(EN_DLY))  dly <= dly + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (pkt_valid) begin
      busy <= 1'b1;
      ph   <= '0;
    end else if (busy) begin
      if (ph == 3'd5) busy <= 1'b0;
      else            ph   <= ph + 1'b1;
    end

  always_comb
    if (!busy) port_sel_out = 2'b01;
    else case (ph[2:1])
      2'd0:    port_sel_out = 2'b01;
      2'd1:    port_sel_out = 2'b00;
      default: port_sel_out = 2'b10;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int g = 0; g < 4; g++) bank[g] <= '0;
    end else if (!bypass) begin
      for (int g = 0; g < 3; g++) begin
        if (pkt_valid)                      bank[g] <= pkt_grp[g];
        if (host_we && host_sel == 2'(g))   bank[g] <= host_data;
        if (port_wr && port_sel_in == 2'(g)) bank[g] <= port_fl_in;
      end
    end

  assign port_fl_out = bypass ? '0 : bank[port_sel_out];
  assign rd_flags    = bypass ? '0 : bank[rd_sel];

  assert_sel_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel_out != 2'b11);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> (port_sel_out == 2'b01) && busy && (ph == 3'd0));

  assert_pair_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ph[0] && !pkt_valid) |=> $stable(port_sel_out));

  assert_bypass_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> ($stable(bank[0]) && $stable(bank[1]) && $stable(bank[2])));

  assert_oe_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_oe) |-> $past(tx_req));

  assert_port_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !bypass && host_we && host_sel == port_sel_in)
      |=> bank[$past(port_sel_in)] == $past(port_fl_in));
endmodule

// File: tb/test_edh_flag_port.sv
module test_edh_flag_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic map_en = 0, rw_sel = 0, bypass = 0, pkt_valid = 0;
  logic [4:0] pkt_anc = 0, pkt_full = 0, pkt_actv = 0, port_fl_in = 0, host_data = 0;
  logic [1:0] port_sel_in = 2'b11, host_sel = 0, rd_sel = 0;
  logic host_we = 0;
  logic [4:0] rd_flags, port_fl_out;
  logic [1:0] port_sel_out;
  logic port_oe;

  edh_flag_port i_edh_flag_port (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .rw_sel(rw_sel), .bypass(bypass),
    .pkt_valid(pkt_valid), .pkt_anc(pkt_anc), .pkt_full(pkt_full), .pkt_actv(pkt_actv),
    .port_fl_in(port_fl_in), .port_sel_in(port_sel_in), .host_we(host_we),
    .host_sel(host_sel), .host_data(host_data), .rd_sel(rd_sel), .rd_flags(rd_flags),
    .port_sel_out(port_sel_out), .port_fl_out(port_fl_out), .port_oe(port_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { string req; logic [1:0] sel; logic [4:0] fl; logic oe; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (port_sel_out !== e.sel || port_fl_out !== e.fl || port_oe !== e.oe) begin
        fails++;
        $display("FAIL %s: sel/fl/oe actual %b/%h/%b expected %b/%h/%b",
                 e.req, port_sel_out, port_fl_out, port_oe, e.sel, e.fl, e.oe);
      end
    end
  end

  task automatic push(string r, logic [1:0] s, logic [4:0] f, logic o);
    exp_t e;
    e.req = r; e.sel = s; e.fl = f; e.oe = o;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic chk(string r, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic rd_chk(string r, logic [1:0] s, logic [4:0] exp);
    rd_sel = s;
    #1;
    chk(r, rd_flags, exp);
  endtask

  task automatic strobe(logic [4:0] a, logic [4:0] f, logic [4:0] v);
    pkt_anc = a; pkt_full = f; pkt_actv = v; pkt_valid = 1'b1;
  endtask

  task automatic full_seq(string r, logic [4:0] a, logic [4:0] f, logic [4:0] v);
    push(r, 2'b01, a, 1); push(r, 2'b01, a, 1);
    push(r, 2'b00, f, 1); push(r, 2'b00, f, 1);
    push(r, 2'b10, v, 1); push(r, 2'b10, v, 1);
    push("R5", 2'b01, a, 1); push("R5", 2'b01, a, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 sel", {3'b0, port_sel_out}, 5'h01);
    chk("R1 oe", {4'b0, port_oe}, 5'h00);
    for (int s = 0; s < 4; s++) rd_chk("R1 rd", 2'(s), 5'h00);

    @(negedge clk) rw_sel = 1'b1;
    @(negedge clk) map_en = 1'b1;
    #1 chk("R2 oe early", {4'b0, port_oe}, 5'h00);
    push("R2", 2'b01, 5'h00, 0);
    push("R2", 2'b01, 5'h00, 1);
    push("R2", 2'b01, 5'h00, 1);
    drain();

    strobe(5'h11, 5'h0A, 5'h15);
    full_seq("R3", 5'h11, 5'h0A, 5'h15);
    @(negedge clk) pkt_valid = 1'b0;
    drain();

    strobe(5'h1B, 5'h02, 5'h04);
    push("R6", 2'b01, 5'h1B, 1); push("R6", 2'b01, 5'h1B, 1);
    push("R6", 2'b00, 5'h02, 1);
    @(negedge clk) pkt_valid = 1'b0;
    drain();
    strobe(5'h03, 5'h1C, 5'h07);
    full_seq("R6", 5'h03, 5'h1C, 5'h07);
    @(negedge clk) pkt_valid = 1'b0;
    drain();

    bypass = 1'b1;
    strobe(5'h1F, 5'h1F, 5'h1F);
    push("R9", 2'b01, 5'h00, 1); push("R9", 2'b01, 5'h00, 1);
    push("R9", 2'b00, 5'h00, 1); push("R9", 2'b00, 5'h00, 1);
    push("R9", 2'b10, 5'h00, 1); push("R9", 2'b10, 5'h00, 1);
    push("R9", 2'b01, 5'h00, 1);
    @(negedge clk) pkt_valid = 1'b0;
    drain();
    bypass = 1'b0;
    #1 chk("R9 idle after bypass", port_fl_out, 5'h03);
    rd_chk("R9 full kept", 2'b00, 5'h1C);
    rd_chk("R10 actv", 2'b10, 5'h07);

    @(negedge clk) map_en = 1'b0;
    #1 chk("R2 oe drop", {4'b0, port_oe}, 5'h00);
    @(negedge clk) rw_sel = 1'b0;

    port_sel_in = 2'b00; port_fl_in = 5'h1F;
    host_we = 1'b1; host_sel = 2'b00; host_data = 5'h01;
    @(negedge clk);
    port_sel_in = 2'b11; port_fl_in = 5'h1E;
    host_sel = 2'b10; host_data = 5'h09;
    rd_chk("R8 port wins", 2'b00, 5'h1F);
    @(negedge clk);
    host_we = 1'b0;
    rd_chk("R8 host write", 2'b10, 5'h09);
    rd_chk("R7 sel 11 ignored", 2'b01, 5'h03);
    rd_chk("R10 sel 11 zero", 2'b11, 5'h00);
    port_sel_in = 2'b10; port_fl_in = 5'h12;
    @(negedge clk);
    port_sel_in = 2'b11;
    rd_chk("R7 port write", 2'b10, 5'h12);

    rw_sel = 1'b1; port_sel_in = 2'b01; port_fl_in = 5'h1A;
    @(negedge clk);
    port_sel_in = 2'b11; rw_sel = 1'b0;
    rd_chk("R7 not write mode", 2'b01, 5'h03);

    @(negedge clk);
    bypass = 1'b1; port_sel_in = 2'b01; port_fl_in = 5'h15;
    host_we = 1'b1; host_sel = 2'b00; host_data = 5'h04;
    rd_chk("R9 rd zero", 2'b00, 5'h00);
    chk("R9 fl zero", port_fl_out, 5'h00);
    @(negedge clk);
    port_sel_in = 2'b11; host_we = 1'b0;
    @(negedge clk) bypass = 1'b0;
    rd_chk("R9 host blocked", 2'b00, 5'h1F);
    rd_chk("R9 port blocked", 2'b01, 5'h03);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule